// File: doc/BRIEF.md
# Cache Control and Invalidate Sequencer

This block is the software-visible control point of an external-memory cache. It holds the cache enable bit and two fill-policy bits, write-allocate enable and critical-word-first disable. It also answers reads of two constant registers: an identity word and a size word. Both constants are set by parameters. The bus side is a plain 32-bit register port. A write strobe is taken on the clock edge where it is high. A read strobe loads the read data register on its edge, and the data is then held until the next read.

Software starts a whole-cache invalidation by writing any value to the invalidate offset. A sequencer then walks a line index from zero to the last line, one line per clock, and pulses a valid-clear strobe with each index. The cache does not have to be disabled first, and the enable bit is left as it was. While the walk runs, the bypass output is forced high and the ready flag in the control word reads 0. A new invalidate write during a walk restarts it from line zero. Leaving reset starts one walk automatically, with the cache disabled.

Top module: `ecache_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, cache_en, wr_alloc_en and cwf_dis are 0 and bypass is 1. A full sweep starts without any bus access: vclr_stb is 1 with vclr_idx 0 in the first cycle after reset.
- R2: A read of offset 0x000 returns the release number (REL_NUM) in bits 5:0, the part number (PART_NUM) in bits 9:6 and the cache identifier (CACHE_ID) in bits 15:10. All other bits read 0.
- R3: A read of offset 0x004 returns the cache size (CACHE_SIZE) in bits 15:0 and the memory size (MEM_SIZE) in bits 31:16.
- R4: A write to offset 0x100 loads bit 0 into cache_en, bit 1 into wr_alloc_en and bit 2 into cwf_dis. The new values show from the next cycle. A read of 0x100 returns those three bits in the same positions and the ready flag in bit 16; all other bits read 0.
- R5: A write to offset 0x700 with any data value starts a sweep. From the next cycle, vclr_stb stays 1 for exactly NUM_LINES cycles, and vclr_idx runs 0, 1, … NUM_LINES-1, one step per cycle. After that, vclr_stb is 0.
- R6: bypass is 1 whenever cache_en is 0 or a sweep is running. The ready flag (bit 16 of 0x100) reads 0 during a sweep. It reads 1 from the cycle after the last index is cleared.
- R7: A sweep leaves cache_en, wr_alloc_en and cwf_dis unchanged.
- R8: A write to 0x700 during a sweep restarts the index at 0 on the next cycle. NUM_LINES strobes then follow.
- R9: A read of 0x700 returns 0.
- R10: Writes to 0x000, 0x004 and to unmapped offsets change no register or output. Reads of unmapped offsets return 0.
- R11: bus_rdata is loaded on the clock edge where bus_rd_en is high and holds its value while bus_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cache_en | output | 1 | Cache enable bit |
| wr_alloc_en | output | 1 | Write-allocate policy bit |
| cwf_dis | output | 1 | Critical-word-first fill disable bit |
| bypass | output | 1 | Datapath must bypass the cache |
| vclr_stb | output | 1 | Clear the valid bit of line vclr_idx this cycle |
| vclr_idx | output | IDX_W | Line index to clear |

## Verification
The assertions assume that bus_addr is driven to a known value whenever either strobe is high. They also assume that a write and a read are never issued in the same cycle. The stimulus issues every access as a one-cycle pulse with the address set up from the preceding falling edge, and never overlaps the two strobes. The sweep checks rely on the bench leaving the invalidate offset untouched for the rest of a walk unless it means to restart it. The restart scenario is the only place where a second write lands mid-walk.

// File: rtl/ecache_ctl_pkg.sv
// Shared definitions for the cache control block: register offsets,
// control-word bit positions and the control state type.
// Assumes byte offsets decoded on a 12-bit address.
package ecache_ctl_pkg;

    localparam int unsigned OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_IDENT = 12'h000;
    localparam logic [OFS_W-1:0] OFS_SIZES = 12'h004;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 12'h100;
    localparam logic [OFS_W-1:0] OFS_INVAL = 12'h700;

    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_WALOC = 1;
    localparam int unsigned BIT_CWFD  = 2;
    localparam int unsigned BIT_RDY   = 16;

    typedef struct packed {
        logic cwf_dis;
        logic wr_alloc;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/ecache_ctl_regs.sv
// Control register holder. Loads the enable and policy bits on a write to
// the control offset and leaves them alone otherwise.
// Assumes the decoder supplies a one-cycle write pulse.
module ecache_ctl_regs
    import ecache_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_we,
    input  logic  wd_en,
    input  logic  wd_waloc,
    input  logic  wd_cwfd,
    output ctrl_t ctrl_q
);

    // Hold the control bits; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.enable   <= wd_en;
            ctrl_q.wr_alloc <= wd_waloc;
            ctrl_q.cwf_dis  <= wd_cwfd;
        end
    end

endmodule

// File: rtl/ecache_ctl_sweep.sv
// Invalidate sequencer. Walks a line index from 0 to NUM_LINES-1, one per
// cycle, raising a clear strobe with each index. A start request restarts
// the walk at 0. Reset begins a walk by itself.
// Assumes NUM_LINES >= 2.
module ecache_ctl_sweep #(
    parameter int unsigned NUM_LINES = 64,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    // Advance, restart or finish the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx  <= idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/ecache_ctl_rdmux.sv
// Read path. Selects the word for the addressed offset and registers it
// when a read strobe is seen. Unmapped and write-only offsets read as zero.
// Assumes the identity fields fit their widths.
module ecache_ctl_rdmux
    import ecache_ctl_pkg::*;
#(
    parameter logic [5:0]  REL_NUM    = 6'h01,
    parameter logic [3:0]  PART_NUM   = 4'h3,
    parameter logic [5:0]  CACHE_ID   = 6'h2A,
    parameter logic [15:0] CACHE_SIZE = 16'h0010,
    parameter logic [15:0] MEM_SIZE   = 16'h0400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] addr,
    input  ctrl_t            ctrl_q,
    input  logic             ready,
    output logic [31:0]      rdata
);

    localparam logic [31:0] IDENT_WORD = {16'h0, CACHE_ID, PART_NUM, REL_NUM};
    localparam logic [31:0] SIZES_WORD = {MEM_SIZE, CACHE_SIZE};

    logic [31:0] sel_word;

    // Pick the word for the current offset.
    always_comb begin
        sel_word = '0;
        unique case (addr)
            OFS_IDENT: sel_word = IDENT_WORD;
            OFS_SIZES: sel_word = SIZES_WORD;
            OFS_CTRL: begin
                sel_word[BIT_EN]    = ctrl_q.enable;
                sel_word[BIT_WALOC] = ctrl_q.wr_alloc;
                sel_word[BIT_CWFD]  = ctrl_q.cwf_dis;
                sel_word[BIT_RDY]   = ready;
            end
            default: sel_word = '0;
        endcase
    end

    // Capture the selected word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel_word;
        end
    end

endmodule

// File: rtl/ecache_ctl.sv
// Top of the cache control block. Decodes the register port, keeps the
// control bits, runs the invalidate sweep and drives bypass.
// Assumes a write and a read never share a cycle.
module ecache_ctl
    import ecache_ctl_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 64,
    parameter logic [5:0]  REL_NUM    = 6'h01,
    parameter logic [3:0]  PART_NUM   = 4'h3,
    parameter logic [5:0]  CACHE_ID   = 6'h2A,
    parameter logic [15:0] CACHE_SIZE = 16'h0010,
    parameter logic [15:0] MEM_SIZE   = 16'h0400,
    localparam int unsigned ADDR_W    = OFS_W,
    localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cache_en,
    output logic              wr_alloc_en,
    output logic              cwf_dis,
    output logic              bypass,
    output logic              vclr_stb,
    output logic [IDX_W-1:0]  vclr_idx
);

    ctrl_t ctrl_q;
    logic  ctrl_we;
    logic  inval_we;
    logic  sweep_busy;
    logic  unused_wdata_hi;

    // Write decode: only the control and invalidate offsets accept writes.
    always_comb begin
        ctrl_we  = bus_wr_en && (bus_addr == OFS_CTRL);
        inval_we = bus_wr_en && (bus_addr == OFS_INVAL);
    end

    assign unused_wdata_hi = ^bus_wdata[31:3];

    ecache_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .wd_en    (bus_wdata[BIT_EN]),
        .wd_waloc (bus_wdata[BIT_WALOC]),
        .wd_cwfd  (bus_wdata[BIT_CWFD]),
        .ctrl_q   (ctrl_q)
    );

    ecache_ctl_sweep #(
        .NUM_LINES (NUM_LINES)
    ) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (inval_we),
        .busy  (sweep_busy),
        .idx   (vclr_idx)
    );

    ecache_ctl_rdmux #(
        .REL_NUM    (REL_NUM),
        .PART_NUM   (PART_NUM),
        .CACHE_ID   (CACHE_ID),
        .CACHE_SIZE (CACHE_SIZE),
        .MEM_SIZE   (MEM_SIZE)
    ) u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_rd_en),
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .ready  (!sweep_busy),
        .rdata  (bus_rdata)
    );

    // Outputs toward the cache datapath.
    always_comb begin
        cache_en    = ctrl_q.enable;
        wr_alloc_en = ctrl_q.wr_alloc;
        cwf_dis     = ctrl_q.cwf_dis;
        vclr_stb    = sweep_busy;
        bypass      = !ctrl_q.enable || sweep_busy;
    end

endmodule

// File: rtl/ecache_ctl_chk.sv
// Port-level checker for ecache_ctl, bound to every instance of the top.
module ecache_ctl_chk
    import ecache_ctl_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr_en,
    input logic             bus_rd_en,
    input logic [OFS_W-1:0] bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             cache_en,
    input logic             bypass,
    input logic             vclr_stb,
    input logic [IDX_W-1:0] vclr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    logic start_now;
    assign start_now = bus_wr_en && (bus_addr == OFS_INVAL);

    // R6: a running sweep always forces bypass.
    a_r6_bypass_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        vclr_stb |-> bypass);

    // R6: a disabled cache is always bypassed.
    a_r6_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |-> bypass);

    // R5: an invalidate write begins a walk at line 0.
    a_r5_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_now |=> (vclr_stb && vclr_idx == '0));

    // R5: the index steps by one each cycle until the last line.
    a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (vclr_stb && !start_now && vclr_idx != LAST_IDX)
        |=> (vclr_stb && vclr_idx == $past(vclr_idx) + IDX_W'(1)));

    // R5: the walk ends after the last line.
    a_r5_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (vclr_stb && !start_now && vclr_idx == LAST_IDX) |=> !vclr_stb);

    // R7: only a control write changes the enable bit.
    a_r7_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_addr == OFS_CTRL) |=> $stable(cache_en));

    // R9: the invalidate offset reads as zero.
    a_r9_inval_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == OFS_INVAL) |=> (bus_rdata == '0));

    // R11: read data holds without a read strobe.
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

endmodule

bind ecache_ctl ecache_ctl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cache_en  (cache_en),
    .bypass    (bypass),
    .vclr_stb  (vclr_stb),
    .vclr_idx  (vclr_idx)
);

// File: tb/ecache_ctl_tb_top.sv
// Directed bench for ecache_ctl: one task per scenario, each checking itself.
module ecache_ctl_tb_top;

    localparam int unsigned NL    = 64;
    localparam int unsigned IW    = $clog2(NL);
    localparam logic [5:0]  P_REL = 6'h05;
    localparam logic [3:0]  P_PRT = 4'h9;
    localparam logic [5:0]  P_CID = 6'h33;
    localparam logic [15:0] P_CSZ = 16'h0020;
    localparam logic [15:0] P_MSZ = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        en, walloc, cwfd, byp, stb;
    logic [IW-1:0] idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ecache_ctl #(
        .NUM_LINES (NL), .REL_NUM (P_REL), .PART_NUM (P_PRT),
        .CACHE_ID (P_CID), .CACHE_SIZE (P_CSZ), .MEM_SIZE (P_MSZ)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .bus_wr_en (wr), .bus_rd_en (rd),
        .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata),
        .cache_en (en), .wr_alloc_en (walloc), .cwf_dis (cwfd),
        .bypass (byp), .vclr_stb (stb), .vclr_idx (idx)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0; addr = '0;
        d = rdata;
    endtask

    // Called on the first strobe cycle; follows the walk and its end.
    task automatic follow_sweep(input string req);
        bit ok = 1'b1;
        logic [31:0] bad_idx = '0;
        for (int k = 0; k < int'(NL); k++) begin
            if (!(stb && byp && idx == IW'(k))) begin
                if (ok) bad_idx = 32'(k);
                ok = 1'b0;
            end
            @(negedge clk);
        end
        chk(ok, req, {31'b0, ok}, 32'h1);
        if (!ok) $display("  first bad index %0d", bad_idx);
        chk(stb == 1'b0, req, {31'b0, stb}, 32'h0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(en == 0 && walloc == 0 && cwfd == 0, "R1", {29'b0, cwfd, walloc, en}, 0);
        chk(byp == 1'b1, "R1", {31'b0, byp}, 1);
        rst_n = 1'b1;
        chk(stb == 1'b1 && idx == '0, "R1", {31'b0, stb}, 1);
        follow_sweep("R1");
        chk(byp == 1'b1, "R6", {31'b0, byp}, 1);
    endtask

    task automatic t_const_regs;
        logic [31:0] d;
        bus_read(12'h000, d);
        chk(d == {16'h0, P_CID, P_PRT, P_REL}, "R2", d, {16'h0, P_CID, P_PRT, P_REL});
        bus_read(12'h004, d);
        chk(d == {P_MSZ, P_CSZ}, "R3", d, {P_MSZ, P_CSZ});
        bus_read(12'h700, d);
        chk(d == 32'h0, "R9", d, 0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        bus_write(12'h100, 32'hFFFF_FFF6);
        chk({cwfd, walloc, en} == 3'b110, "R4", {29'b0, cwfd, walloc, en}, 32'h6);
        chk(byp == 1'b1, "R6", {31'b0, byp}, 1);
        bus_read(12'h100, d);
        chk(d == 32'h0001_0006, "R4", d, 32'h0001_0006);
        bus_write(12'h100, 32'h0000_0003);
        chk({cwfd, walloc, en} == 3'b011, "R4", {29'b0, cwfd, walloc, en}, 32'h3);
        chk(byp == 1'b0, "R6", {31'b0, byp}, 0);
        bus_read(12'h100, d);
        chk(d == 32'h0001_0003, "R4", d, 32'h0001_0003);
    endtask

    task automatic t_ignored_writes;
        logic [31:0] d;
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_write(12'h004, 32'h0000_0000);
        bus_write(12'h104, 32'h0000_0000);
        bus_write(12'h0FC, 32'h0000_0000);
        chk({cwfd, walloc, en} == 3'b011 && !stb, "R10", {28'b0, stb, cwfd, walloc, en}, 32'h3);
        bus_read(12'h000, d);
        chk(d == {16'h0, P_CID, P_PRT, P_REL}, "R10", d, {16'h0, P_CID, P_PRT, P_REL});
        bus_read(12'h004, d);
        chk(d == {P_MSZ, P_CSZ}, "R10", d, {P_MSZ, P_CSZ});
        bus_read(12'h200, d);
        chk(d == 32'h0, "R10", d, 0);
    endtask

    task automatic t_read_hold;
        logic [31:0] d;
        bus_read(12'h004, d);
        repeat (4) @(negedge clk);
        chk(rdata == {P_MSZ, P_CSZ}, "R11", rdata, {P_MSZ, P_CSZ});
    endtask

    task automatic t_inval_enabled;
        logic [31:0] d;
        bus_write(12'h700, 32'h0000_0000);
        chk(en == 1'b1 && byp == 1'b1, "R7", {30'b0, byp, en}, 32'h3);
        follow_sweep("R5");
        chk({cwfd, walloc, en} == 3'b011, "R7", {29'b0, cwfd, walloc, en}, 32'h3);
        chk(byp == 1'b0, "R6", {31'b0, byp}, 0);
        bus_read(12'h100, d);
        chk(d[16] == 1'b1, "R6", d, 32'h0001_0003);
    endtask

    task automatic t_ready_low;
        logic [31:0] d;
        bus_write(12'h700, 32'hDEAD_BEEF);
        bus_read(12'h100, d);
        chk(d == 32'h0000_0003, "R6", d, 32'h0000_0003);
        repeat (int'(NL)) @(negedge clk);
        chk(stb == 1'b0 && byp == 1'b0, "R6", {30'b0, stb, byp}, 0);
        bus_read(12'h100, d);
        chk(d == 32'h0001_0003, "R6", d, 32'h0001_0003);
    endtask

    task automatic t_restart;
        bus_write(12'h700, 32'hFFFF_FFFF);
        repeat (10) @(negedge clk);
        chk(stb && idx == IW'(10), "R8", {{(32-IW){1'b0}}, idx}, 10);
        bus_write(12'h700, 32'h1234_5678);
        follow_sweep("R8");
    endtask

    initial begin
        t_reset();
        t_const_regs();
        t_ctrl();
        t_ignored_writes();
        t_read_hold();
        t_inval_enabled();
        t_ready_low();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule